// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide register file that sits between a processor bus and a 16550-compatible serial port. Eight offsets are decoded from a 3-bit address. A single-cycle access strobe with a write flag either stores a byte or returns read data combinationally in the same cycle, and any side effect of a read takes hold at the clock edge that closes the access. Serialization, baud timing and modem pins are handled elsewhere. This block exchanges whole bytes: transmitted bytes leave as a one-cycle valid/data pulse, and received bytes arrive through a push port with a ready signal.

The receive queue holds a single entry until software enables FIFO mode, and then holds `DEPTH` entries. A loopback request input turns data-register writes back into the receive queue. The block ranks four interrupt causes into an identification code and drives one level interrupt line. That line is computed from the registered state, so it reflects every access and push as soon as the edge that applies it has passed.

Top module: `ser_uart_regs`

## Requirements
- R1: After reset the divisor low byte is 12 and the high byte is 0 (1843200 Hz reference, 9600 baud, 16x oversampling). The identification read (offset 2) returns 0x01, the line status read (offset 5) returns 0x60, `irq_o` is low and the receive queue holds one entry.
- R2: When line-control (offset 3) bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. In that state the data register, the receive queue and the enable register are not touched.
- R3: A write to the enable register (offset 1, bit 7 of line control clear) keeps bits 3:0, and bits 7:4 read as zero. Bit 0 enables receive data, bit 1 enables transmit-empty, bit 2 enables line status and bit 3 enables modem delta.
- R4: The identification read returns the highest active cause in its low nibble. Overrun gives 0x6, receive data present gives 0x4, transmit-empty pending gives 0x2, any modem delta gives 0x0 and no cause gives 0x1. Each cause counts only while its enable bit is set.
- R5: `irq_o` is high exactly when a cause other than "none" is active in the current registered state.
- R6: A data write (offset 0) sets the transmit-empty pending flag. Without loopback it produces `tx_valid_o` for one cycle, in the cycle after the write, carrying the byte. With `loop_i` high the byte goes into the receive queue instead and nothing is transmitted. An identification read that reports code 0x2 clears the pending flag.
- R7: A FIFO-control write (offset 2) whose bit 0 differs from the current mode flushes the queue and resizes it, to `DEPTH` entries when enabling and to 1 when disabling. With bit 0 clear every other bit is ignored. With bits 0 and 1 both set the queue is flushed. While FIFO mode is on, bits 7:6 of the identification read are 1.
- R8: The line status read has bits 6 and 5 always set, bit 0 set exactly when the queue is non-empty and bit 1 holding the overrun flag. The read clears overrun unless a new overrun happens in the same cycle.
- R9: A data read pops and returns the oldest queued byte. On an empty queue it returns 0 and changes nothing.
- R10: `rx_ready_o` is low while the queue is full or `loop_i` is high. A push, or a loopback write, into a full queue drops the byte and sets overrun.
- R11: Writes to offsets 4, 5 and 6 are ignored. Offset 4 reads 0 and offset 6 reads the modem delta input in bits 3:0. Offset 7 is a plain read/write scratch byte.
- R12: Any set bit of `mdm_delta_i` is a modem cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during a read access, 0 otherwise |
| tx_valid_o | output | 1 | Transmit byte valid, one-cycle pulse |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Receive push request |
| rx_data_i | input | 8 | Receive push byte |
| rx_ready_o | output | 1 | Receive push can be accepted |
| loop_i | input | 1 | Loopback request |
| mdm_delta_i | input | 4 | Modem status change flags |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is one where every interrupt cause is active at once and the causes are then retired one by one, so that each lower rank is seen taking over. The stimulus builds this state deliberately. It fills a one-entry queue and pushes again to raise overrun, writes a byte to leave transmit-empty pending, and holds a modem delta. It then reads the identification register after each clearing access: a line status read, a data pop, and the identification read that retires the transmit-empty flag. A long random phase also produces pushes that coincide with FIFO-mode flips, pops and line status reads, and a behavioural queue model checks every one of those cycles.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [3:0] {
    IID_MODEM  = 4'h0,
    IID_NONE   = 4'h1,
    IID_THRE   = 4'h2,
    IID_RXDATA = 4'h4,
    IID_LINE   = 4'h6
  } iid_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_IID  = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4;
  localparam logic [2:0] OFS_LSTA = 3'd5;
  localparam logic [2:0] OFS_MSTA = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;
endpackage

// File: rtl/ser_rx_fifo.sv
module ser_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         big_i,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP_BIG = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_ONE = CW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q, cap;
  logic          pop_ok;

  assign cap     = big_i ? CAP_BIG : CAP_ONE;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q >= cap);
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = empty_o ? '0 : mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[flush_i ? '0 : wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      // a push accepted in the flush cycle lands in the fresh queue
      rd_q  <= '0;
      wr_q  <= push_i ? AW'(1) : '0;
      cnt_q <= push_i ? CW'(1) : '0;
    end else begin
      if (push_i) wr_q <= wr_q + AW'(1);
      if (pop_ok) rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_ok);
    end
  end

  AST_CNT_WITHIN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CAP_BIG) else $error("count above depth"); // R7
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> !full_o) else $error("push into full queue"); // R10
endmodule

// File: rtl/ser_irq_prio.sv
module ser_irq_prio
  import ser_pkg::*;
(
  input  logic       ovr_i,
  input  logic       rx_i,
  input  logic       thre_i,
  input  logic [3:0] mdm_i,
  input  logic [3:0] ien_i,
  output iid_e       iid_o,
  output logic       irq_o
);
  always_comb begin
    if (ovr_i && ien_i[2])               iid_o = IID_LINE;
    else if (rx_i && ien_i[0])           iid_o = IID_RXDATA;
    else if (thre_i && ien_i[1])         iid_o = IID_THRE;
    else if ((|mdm_i) && ien_i[3])       iid_o = IID_MODEM;
    else                                 iid_o = IID_NONE;
  end

  assign irq_o = (iid_o != IID_NONE);
endmodule

// File: rtl/ser_uart_regs.sv
module ser_uart_regs
  import ser_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REF_HZ = 1843200,
  parameter int BAUD   = 9600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_ready_o,
  input  logic       loop_i,
  input  logic [3:0] mdm_delta_i,
  output logic       irq_o
);
  localparam int DIV = REF_HZ / (BAUD * 16);
  localparam logic [15:0] DIV_INIT = DIV[15:0];

  logic [7:0] dll_q, dlh_q, lctl_q, scr_q;
  logic [3:0] ien_q;
  logic       fifo_en_q, ovr_q, thre_q;
  logic [7:0] tx_data_q;
  logic       tx_valid_q;

  logic dlab, rd, we;
  logic wr_data, wr_dll, wr_dlh, wr_ien, wr_fctl, wr_lctl, wr_scr;
  logic rd_data, rd_iid, rd_lsta;
  logic flush, push, ovr_set, rx_acc, lb_push;
  logic fifo_empty, fifo_full;
  logic [7:0] fifo_dout, push_data;
  iid_e iid;

  assign dlab = lctl_q[7];
  assign rd   = sel_i && !wr_i;
  assign we   = sel_i &&  wr_i;

  assign wr_data = we && addr_i == OFS_DATA && !dlab;
  assign wr_dll  = we && addr_i == OFS_DATA &&  dlab;
  assign wr_ien  = we && addr_i == OFS_IEN  && !dlab;
  assign wr_dlh  = we && addr_i == OFS_IEN  &&  dlab;
  assign wr_fctl = we && addr_i == OFS_IID;
  assign wr_lctl = we && addr_i == OFS_LCTL;
  assign wr_scr  = we && addr_i == OFS_SCR;
  assign rd_data = rd && addr_i == OFS_DATA && !dlab;
  assign rd_iid  = rd && addr_i == OFS_IID;
  assign rd_lsta = rd && addr_i == OFS_LSTA;

  // mode flip flushes; receiver reset only counts with enable set
  assign flush = wr_fctl && ((wdata_i[0] != fifo_en_q) || (wdata_i[0] && wdata_i[1]));

  assign rx_ready_o = !loop_i && !fifo_full;
  assign rx_acc     = rx_valid_i && rx_ready_o;
  assign lb_push    = wr_data && loop_i && !fifo_full;
  assign push       = rx_acc || lb_push;
  assign push_data  = lb_push ? wdata_i : rx_data_i;
  assign ovr_set    = (rx_valid_i && !loop_i && fifo_full) || (wr_data && loop_i && fifo_full);

  ser_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .big_i   (fifo_en_q),
    .flush_i (flush),
    .push_i  (push),
    .din_i   (push_data),
    .pop_i   (rd_data),
    .dout_o  (fifo_dout),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  ser_irq_prio u_prio (
    .ovr_i  (ovr_q),
    .rx_i   (!fifo_empty),
    .thre_i (thre_q),
    .mdm_i  (mdm_delta_i),
    .ien_i  (ien_q),
    .iid_o  (iid),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q     <= DIV_INIT[7:0];
      dlh_q     <= DIV_INIT[15:8];
      lctl_q    <= '0;
      ien_q     <= '0;
      scr_q     <= '0;
      fifo_en_q <= 1'b0;
    end else begin
      if (wr_dll)  dll_q     <= wdata_i;
      if (wr_dlh)  dlh_q     <= wdata_i;
      if (wr_lctl) lctl_q    <= wdata_i;
      if (wr_ien)  ien_q     <= wdata_i[3:0];
      if (wr_scr)  scr_q     <= wdata_i;
      if (wr_fctl) fifo_en_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      thre_q <= 1'b0;
    end else begin
      if (ovr_set)      ovr_q <= 1'b1;
      else if (rd_lsta) ovr_q <= 1'b0;
      if (wr_data)                         thre_q <= 1'b1;
      else if (rd_iid && iid == IID_THRE)  thre_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= wr_data && !loop_i;
      if (wr_data && !loop_i) tx_data_q <= wdata_i;
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_DATA: rdata_o = dlab ? dll_q : fifo_dout;
        OFS_IEN:  rdata_o = dlab ? dlh_q : {4'b0000, ien_q};
        OFS_IID:  rdata_o = {fifo_en_q, fifo_en_q, 2'b00, iid};
        OFS_LCTL: rdata_o = lctl_q;
        OFS_MCTL: rdata_o = '0;
        OFS_LSTA: rdata_o = {1'b0, 1'b1, 1'b1, 3'b000, ovr_q, !fifo_empty};
        OFS_MSTA: rdata_o = {4'b0000, mdm_delta_i};
        OFS_SCR:  rdata_o = scr_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_TX_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !loop_i) |=> (tx_valid_o && tx_data_o == $past(wdata_i))) else $error("tx echo"); // R6
  AST_NO_TX_IN_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && loop_i) |=> !tx_valid_o) else $error("tx during loopback"); // R6
  AST_THRE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_iid && iid == IID_THRE) |=> !thre_q) else $error("thre not cleared"); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set |=> ovr_q) else $error("overrun lost"); // R10
  AST_NO_READY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |-> !rx_ready_o) else $error("ready while full"); // R10
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && fifo_empty) |-> rdata_o == 8'h00) else $error("empty read nonzero"); // R9
  AST_LSR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lsta && !ovr_set) |=> !ovr_q) else $error("overrun not cleared"); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush && !push) |=> fifo_empty) else $error("flush left data"); // R7
endmodule

// File: tb/sim_ser_uart_regs.sv
module sim_ser_uart_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, loop = 1'b0, rxv = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wd = '0, rxd = '0;
  logic [3:0] mdelta = '0;
  logic [7:0] rdata, txd;
  logic       txv, rdy, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_uart_regs #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .tx_valid_o(txv), .tx_data_o(txd),
    .rx_valid_i(rxv), .rx_data_i(rxd), .rx_ready_o(rdy), .loop_i(loop),
    .mdm_delta_i(mdelta), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0] m_dll, m_dlh, m_lcr, m_scr;
  logic [3:0] m_ier;
  bit m_fen, m_ovr, m_thre, m_txv;
  logic [7:0] m_txd;
  logic [7:0] q[$];

  function automatic int cap();
    return m_fen ? DEPTH : 1;
  endfunction

  function automatic logic [3:0] cause();
    if (m_ovr && m_ier[2]) return 4'h6;
    if (q.size() > 0 && m_ier[0]) return 4'h4;
    if (m_thre && m_ier[1]) return 4'h2;
    if (mdelta != 0 && m_ier[3]) return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic [7:0] exp_rd();
    if (!(sel && !wr)) return 8'h00;
    case (addr)
      3'd0: return m_lcr[7] ? m_dll : (q.size() > 0 ? q[0] : 8'h00);
      3'd1: return m_lcr[7] ? m_dlh : {4'h0, m_ier};
      3'd2: return (m_fen ? 8'hC0 : 8'h00) | {4'h0, cause()};
      3'd3: return m_lcr;
      3'd5: return 8'h60 | (m_ovr ? 8'h02 : 8'h00) | (q.size() > 0 ? 8'h01 : 8'h00);
      3'd6: return {4'h0, mdelta};
      3'd7: return m_scr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_dll = 8'd12; m_dlh = 8'd0; m_lcr = 0; m_scr = 0; m_ier = 0;
    m_fen = 0; m_ovr = 0; m_thre = 0; m_txv = 0; m_txd = 0;
    q.delete();
  endtask

  task automatic model_step();
    bit full = (q.size() >= cap());
    bit ready = !loop && !full;
    bit ovr_ev = rxv && !loop && full;
    logic [3:0] c = cause();
    bit dlab = m_lcr[7];
    m_txv = 0;
    if (sel && !wr) begin
      if (addr == 0 && !dlab && q.size() > 0) void'(q.pop_front());
      if (addr == 2 && c == 4'h2) m_thre = 0;
      if (addr == 5) m_ovr = 0;
    end
    if (sel && wr) begin
      case (addr)
        3'd0: if (dlab) m_dll = wd;
              else begin
                m_thre = 1;
                if (loop) begin
                  if (full) ovr_ev = 1; else q.push_back(wd);
                end else begin m_txv = 1; m_txd = wd; end
              end
        3'd1: if (dlab) m_dlh = wd; else m_ier = wd[3:0];
        3'd2: begin
                if (wd[0] != m_fen || (wd[0] && wd[1])) q.delete();
                m_fen = wd[0];
              end
        3'd3: m_lcr = wd;
        3'd7: m_scr = wd;
        default: ;
      endcase
    end
    if (rxv && ready) q.push_back(rxd);
    if (ovr_ev) m_ovr = 1;
  endtask

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", cur_req, what, act, exp);
    end
  endtask

  // inputs already set just after a falling edge
  task automatic tick();
    #1;
    chk("rdata", rdata, exp_rd());
    chk("rx_ready", {7'd0, rdy}, {7'd0, !loop && q.size() < cap()});
    chk("irq", {7'd0, irq}, {7'd0, cause() != 4'h1});
    model_step();
    @(posedge clk); @(negedge clk);
    chk("tx_valid", {7'd0, txv}, {7'd0, m_txv});
    if (m_txv) chk("tx_data", txd, m_txd);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    sel = 1; wr = 1; addr = a; wd = d; tick(); sel = 0; wr = 0;
  endtask
  task automatic bus_rd(input logic [2:0] a);
    sel = 1; wr = 0; addr = a; tick(); sel = 0;
  endtask
  task automatic push(input logic [7:0] d);
    rxv = 1; rxd = d; tick(); rxv = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    cur_req = "R1";
    tick(); bus_rd(3'd5); bus_rd(3'd2);
    bus_wr(3'd3, 8'h80); bus_rd(3'd0); bus_rd(3'd1); bus_wr(3'd3, 8'h00);
    push(8'h11); push(8'h22); bus_rd(3'd0); bus_rd(3'd5);
    // R2 divisor access through line control bit 7
    cur_req = "R2";
    push(8'h5A);
    bus_wr(3'd3, 8'h83); bus_wr(3'd0, 8'h34); bus_wr(3'd1, 8'hF1);
    bus_rd(3'd0); bus_rd(3'd1); bus_wr(3'd3, 8'h03);
    bus_rd(3'd1); bus_rd(3'd0); bus_rd(3'd0);
    // R3 enable masking
    cur_req = "R3";
    bus_wr(3'd1, 8'hFF); bus_rd(3'd1); bus_wr(3'd1, 8'hA0); bus_rd(3'd1);
    // R6 transmit and loopback
    cur_req = "R6";
    bus_wr(3'd1, 8'h02); bus_wr(3'd0, 8'hC3); tick();
    bus_rd(3'd2); bus_rd(3'd2);
    loop = 1; push(8'h77); bus_wr(3'd0, 8'h9E); bus_wr(3'd0, 8'h9F);
    bus_rd(3'd5); bus_rd(3'd0); loop = 0; bus_rd(3'd2);
    // R9 R10 single entry queue, overrun
    cur_req = "R10";
    bus_wr(3'd1, 8'h00); push(8'hA1); push(8'hA2); bus_rd(3'd5);
    cur_req = "R8"; bus_rd(3'd5);
    cur_req = "R9"; bus_rd(3'd0); bus_rd(3'd0);
    // R7 FIFO mode
    cur_req = "R7";
    bus_wr(3'd2, 8'h01); bus_rd(3'd2);
    for (int i = 0; i < DEPTH; i++) push(8'(8'h30 + i));
    cur_req = "R10"; push(8'hEE); bus_rd(3'd5);
    cur_req = "R9"; bus_rd(3'd0); bus_rd(3'd0);
    cur_req = "R7";
    bus_wr(3'd2, 8'h03); bus_rd(3'd5);
    push(8'h41); push(8'h42); push(8'h43); bus_wr(3'd2, 8'hC9); bus_rd(3'd0);
    bus_wr(3'd2, 8'h00); bus_rd(3'd5); bus_rd(3'd2);
    push(8'h44); bus_wr(3'd2, 8'h06); bus_rd(3'd5); bus_rd(3'd0);
    // R4 R5 R12 full ranking walk
    cur_req = "R4";
    bus_wr(3'd1, 8'h0F); push(8'h51); push(8'h52); bus_wr(3'd0, 8'h60);
    mdelta = 4'b0100;
    bus_rd(3'd2); bus_rd(3'd5); bus_rd(3'd2); bus_rd(3'd0);
    bus_rd(3'd2); bus_rd(3'd2);
    cur_req = "R12"; bus_rd(3'd6); mdelta = 4'b0000; tick();
    cur_req = "R5"; bus_rd(3'd2); bus_wr(3'd1, 8'h00); mdelta = 4'b1000; tick();
    mdelta = 0;
    // R11 ignored offsets and scratch
    cur_req = "R11";
    bus_wr(3'd5, 8'hFF); bus_rd(3'd5); bus_wr(3'd6, 8'hFF); bus_rd(3'd6);
    bus_wr(3'd4, 8'hFF); bus_rd(3'd4); bus_wr(3'd7, 8'hA5); bus_rd(3'd7);
    // random mix, compared every cycle
    cur_req = "R4/R9";
    for (int i = 0; i < 600; i++) begin
      sel = ($urandom % 3) != 0; wr = $urandom % 2; addr = 3'($urandom);
      wd = 8'($urandom);
      if (addr == 3'd3 && wr) wd[7] = ($urandom % 4) == 0;
      loop = ($urandom % 6) == 0; rxv = $urandom % 2; rxd = 8'($urandom);
      mdelta = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      tick();
    end
    sel = 0; wr = 0; loop = 0; rxv = 0; mdelta = 0;
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule